// File: doc/BRIEF.md
# Compare and Status Flag Unit

This block compares two integer operands by subtracting the second from the first. The difference is never returned or stored. Only six status flags come out of it: borrow (`cf`), signed overflow (`of`), sign (`sf`), zero (`zf`), nibble borrow (`af`) and low-byte parity (`pf`). It takes an opcode byte and a three-bit extension field, which it decodes into an operand width of 8, 16 or 32 bits and an operand order. For the forms that carry an immediate, it sign-extends the immediate up to the width of the first operand.

A caller presents one compare at a time with `in_valid` high. The register/memory value goes on `rm_val`, and for the accumulator forms this port carries the accumulator. The register value goes on `src_reg`, and any immediate goes on `imm_val`. One clock later `flg_valid` pulses and the registered flags show the result. When the opcode is not a compare, no strobe is raised and the flags keep their previous values.

Top module: `cmpu_top`

## Requirements
- R1: A cycle with `in_valid` high and a recognised compare opcode produces `flg_valid` high in the following cycle, with the flags for that compare. In every other case `flg_valid` is low in the following cycle.
- R2: A cycle that carries no recognised compare leaves all six flags unchanged. This covers `in_valid` low, an opcode outside the compare set, and 0x80/0x81/0x83 with `ext_field` not equal to 7.
- R3: `cf` is 1 exactly when the first operand, masked to the selected width, is unsigned-less-than the second operand masked the same way.
- R4: `zf` is 1 exactly when the difference is zero at the selected width. Operand bits above that width have no effect on any flag.
- R5: `sf` equals the top bit of the difference at the selected width. `of` is 1 when the operands differ in sign and the sign of the difference differs from the sign of the first operand.
- R6: `af` is 1 exactly when bits 3..0 of the first operand, taken as an unsigned value, are less than bits 3..0 of the second operand.
- R7: `pf` is 1 when bits 7..0 of the difference hold an even number of ones. This applies at every width.
- R8: For 0x38, 0x39, 0x3C, 0x3D, 0x80, 0x81 and 0x83 the first operand is `rm_val`. For 0x3A and 0x3B the first operand is `src_reg` and the second is `rm_val`. For 0x38 and 0x39 the second operand is `src_reg`.
- R9: For 0x3C, 0x80 and 0x83 the second operand is `imm_val[7:0]` sign-extended to the operand width. For 0x3D and 0x81 it is `imm_val` at the operand width.
- R10: Opcodes 0x38, 0x3A, 0x3C and 0x80 use 8-bit width. Opcodes 0x39, 0x3B, 0x3D, 0x81 and 0x83 use 32 bits when `wide32` is 1 and 16 bits when it is 0.
- R11: While `rst` is high at a clock edge, `flg_valid` and all flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request in this cycle |
| opcode | input | 8 | Opcode byte selecting form, width class and order |
| ext_field | input | 3 | Extension field; must be 7 for the 0x80/0x81/0x83 forms |
| wide32 | input | 1 | 1 selects 32-bit, 0 selects 16-bit for non-byte forms |
| rm_val | input | 32 | Register/memory operand, or the accumulator for 0x3C/0x3D |
| src_reg | input | 32 | Register operand |
| imm_val | input | 32 | Immediate operand |
| flg_valid | output | 1 | Flags updated by a compare in the previous cycle |
| cf | output | 1 | Unsigned borrow |
| of | output | 1 | Signed overflow |
| sf | output | 1 | Sign of the difference |
| zf | output | 1 | Difference is zero |
| af | output | 1 | Borrow out of bit 3 |
| pf | output | 1 | Even parity of the difference's low byte |

## Verification
The embedded checks assume that every input is a known value at each clock edge after reset. They also assume that a recognised compare always yields flags that agree with one another, for example that a zero difference can never come with a borrow, an overflow or odd parity. The stimulus holds every input at a defined value throughout, changes inputs only on the falling edge, and never leaves an input undriven between requests. The byte-width space is swept completely through opcode 0x38. The wider widths, each operand order and each immediate form are exercised with directed values whose upper bits are deliberately non-zero.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef enum logic [1:0] {SZ8, SZ16, SZ32} size_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } flags_t;

  localparam logic [7:0] OP_RM_R8   = 8'h38;
  localparam logic [7:0] OP_RM_RW   = 8'h39;
  localparam logic [7:0] OP_R_RM8   = 8'h3A;
  localparam logic [7:0] OP_R_RMW   = 8'h3B;
  localparam logic [7:0] OP_ACC_I8  = 8'h3C;
  localparam logic [7:0] OP_ACC_IW  = 8'h3D;
  localparam logic [7:0] OP_GRP_B   = 8'h80;
  localparam logic [7:0] OP_GRP_W   = 8'h81;
  localparam logic [7:0] OP_GRP_WB  = 8'h83;
  localparam logic [2:0] EXT_CMP    = 3'd7;
endpackage

// File: rtl/cmpu_decode.sv
module cmpu_decode
  import cmpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        opcode,
  input  logic [2:0]        ext_field,
  input  logic              wide32,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [DATA_W-1:0] imm_val,
  output logic              hit,
  output size_e             size,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] imm_b8;
  logic [DATA_W-1:0] imm_w;
  logic              byte_form;

  assign imm_b8 = {{(DATA_W-8){imm_val[7]}}, imm_val[7:0]};
  assign imm_w  = wide32 ? imm_val : {{(DATA_W-HALF_W){imm_val[HALF_W-1]}}, imm_val[HALF_W-1:0]};

  assign byte_form = (opcode == OP_RM_R8) || (opcode == OP_R_RM8) ||
                     (opcode == OP_ACC_I8) || (opcode == OP_GRP_B);

  always_comb begin
    size = byte_form ? SZ8 : (wide32 ? SZ32 : SZ16);
  end

  always_comb begin
    hit  = 1'b0;
    op_a = rm_val;
    op_b = src_reg;
    case (opcode)
      OP_RM_R8, OP_RM_RW: hit = 1'b1;
      OP_R_RM8, OP_R_RMW: begin
        hit  = 1'b1;
        op_a = src_reg;
        op_b = rm_val;
      end
      OP_ACC_I8: begin
        hit  = 1'b1;
        op_b = imm_b8;
      end
      OP_ACC_IW: begin
        hit  = 1'b1;
        op_b = imm_w;
      end
      OP_GRP_B, OP_GRP_WB: begin
        hit  = (ext_field == EXT_CMP);
        op_b = imm_b8;
      end
      OP_GRP_W: begin
        hit  = (ext_field == EXT_CMP);
        op_b = imm_w;
      end
      default: hit = 1'b0;
    endcase
  end

  // R9: the short-immediate forms carry a sign-extended second operand
  always_comb begin
    if (opcode == OP_GRP_WB)
      p_sext_r9: assert (op_b[DATA_W-1:8] == {(DATA_W-8){imm_val[7]}});
  end
endmodule

// File: rtl/cmpu_flags.sv
module cmpu_flags
  import cmpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  size_e             size,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output flags_t            flags
);
  localparam int IDX_W = $clog2(DATA_W) + 1;

  logic [IDX_W-1:0]  msb;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic [DATA_W:0]   diff;

  always_comb begin
    case (size)
      SZ8:     msb = IDX_W'(7);
      SZ16:    msb = IDX_W'(15);
      default: msb = IDX_W'(DATA_W - 1);
    endcase
    mask = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - msb);
    a_m  = op_a & mask;
    b_m  = op_b & mask;
    diff = {1'b0, a_m} - {1'b0, b_m};
  end

  always_comb begin
    flags.cf = diff[msb + IDX_W'(1)];
    flags.sf = diff[msb];
    flags.zf = ((diff[DATA_W-1:0] & mask) == '0);
    flags.of = (a_m[msb] ^ b_m[msb]) & (diff[msb] ^ a_m[msb]);
    flags.af = a_m[4] ^ b_m[4] ^ diff[4];
    flags.pf = ~^diff[7:0];
  end

  // R3: borrow agrees with an unsigned magnitude comparison
  always_comb begin
    p_borrow_r3: assert (flags.cf == (a_m < b_m));
  end

  // R5: overflow only when the operand signs differ
  always_comb begin
    if (flags.of)
      p_ovf_sign_r5: assert (a_m[msb] != b_m[msb]);
  end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [2:0]        ext_field,
  input  logic              wide32,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [DATA_W-1:0] imm_val,
  output logic              flg_valid,
  output logic              cf,
  output logic              of,
  output logic              sf,
  output logic              zf,
  output logic              af,
  output logic              pf
);
  logic              dec_hit;
  size_e             dec_size;
  logic [DATA_W-1:0] dec_a;
  logic [DATA_W-1:0] dec_b;
  flags_t            flags_c;
  flags_t            flags_q;
  logic              take;

  cmpu_decode #(.DATA_W(DATA_W)) u_decode (
    .opcode    (opcode),
    .ext_field (ext_field),
    .wide32    (wide32),
    .rm_val    (rm_val),
    .src_reg   (src_reg),
    .imm_val   (imm_val),
    .hit       (dec_hit),
    .size      (dec_size),
    .op_a      (dec_a),
    .op_b      (dec_b)
  );

  cmpu_flags #(.DATA_W(DATA_W)) u_flags (
    .size  (dec_size),
    .op_a  (dec_a),
    .op_b  (dec_b),
    .flags (flags_c)
  );

  assign take = in_valid & dec_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_valid <= 1'b0;
      flags_q   <= '0;
    end else begin
      flg_valid <= take;
      if (take)
        flags_q <= flags_c;
    end
  end

  assign cf = flags_q.cf;
  assign of = flags_q.of;
  assign sf = flags_q.sf;
  assign zf = flags_q.zf;
  assign af = flags_q.af;
  assign pf = flags_q.pf;

  // R1: an accepted compare is reported one cycle later
  p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_hit) |=> flg_valid);

  // R2: a cycle without a compare raises no strobe and keeps the flags
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && dec_hit) |=> (!flg_valid && $stable({cf, of, sf, zf, af, pf})));

  // R4: a zero difference cannot come with borrow, sign, overflow or odd parity
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (flg_valid && zf) |-> (!cf && !of && !sf && !af && pf));
endmodule

// File: tb/tb_cmpu_top.sv
module tb_cmpu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  ext_field = 3'd0;
  logic        wide32 = 1'b0;
  logic [31:0] rm_val = '0;
  logic [31:0] src_reg = '0;
  logic [31:0] imm_val = '0;
  logic        flg_valid, cf, of, sf, zf, af, pf;

  int total = 0;
  int bad = 0;
  logic [5:0] last_flags = '0;

  always #10 clk = ~clk;

  cmpu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .ext_field(ext_field), .wide32(wide32), .rm_val(rm_val),
    .src_reg(src_reg), .imm_val(imm_val), .flg_valid(flg_valid),
    .cf(cf), .of(of), .sf(sf), .zf(zf), .af(af), .pf(pf)
  );

  function automatic logic [5:0] model(longint unsigned a_in, longint unsigned b_in, int w);
    longint unsigned m, a, b, d;
    longint sa, sb, sd, half;
    logic e_cf, e_of, e_sf, e_zf, e_af, e_pf;
    int ones;
    m = (64'd1 << w) - 1;
    a = a_in & m;
    b = b_in & m;
    half = longint'(64'd1 << (w - 1));
    e_cf = (a < b);
    d = (a - b) & m;
    e_sf = ((d >> (w - 1)) & 1) != 0;
    e_zf = (d == 0);
    sa = (longint'(a) >= half) ? longint'(a) - 2 * half : longint'(a);
    sb = (longint'(b) >= half) ? longint'(b) - 2 * half : longint'(b);
    sd = sa - sb;
    e_of = (sd > half - 1) || (sd < -half);
    e_af = ((a & 15) < (b & 15));
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'((d >> k) & 1);
    e_pf = (ones % 2) == 0;
    return {e_cf, e_of, e_sf, e_zf, e_af, e_pf};
  endfunction

  task automatic chk(string tag, logic [7:0] op, logic [2:0] ext, logic wd,
                     logic [31:0] rm, logic [31:0] rg, logic [31:0] im,
                     logic go, logic exp_hit, logic [31:0] ea, logic [31:0] eb, int w);
    logic [6:0] exp_v, got;
    in_valid = go; opcode = op; ext_field = ext; wide32 = wd;
    rm_val = rm; src_reg = rg; imm_val = im;
    @(negedge clk);
    if (exp_hit) begin
      exp_v = {1'b1, model(longint'(ea), longint'(eb), w)};
      last_flags = exp_v[5:0];
    end else begin
      exp_v = {1'b0, last_flags};
    end
    got = {flg_valid, cf, of, sf, zf, af, pf};
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s op=%h rm=%h reg=%h imm=%h got=%b exp=%b", tag, op, rm, rg, im, got, exp_v);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    total++;
    if ({flg_valid, cf, of, sf, zf, af, pf} !== 7'b0) begin
      bad++;
      $display("FAIL R11 reset got=%b exp=%b", {flg_valid, cf, of, sf, zf, af, pf}, 7'b0);
    end
    rst = 1'b0;

    // R3 R5 R6 R7: every byte pair through 0x38
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        chk("R3/R5/R6/R7 byte sweep", 8'h38, 3'd0, 1'b0, 32'(i), 32'(j), 32'h0,
            1'b1, 1'b1, 32'(i), 32'(j), 8);

    // R4 R10: 16-bit with garbage upper halves, equal low halves
    chk("R4 16-bit upper bits ignored", 8'h39, 3'd0, 1'b0, 32'hABCD1234, 32'h55551234, 32'h0,
        1'b1, 1'b1, 32'h1234, 32'h1234, 16);
    // R4 R10: 16-bit sweep of a few patterns with noisy upper bits
    for (int i = 0; i < 64; i++)
      chk("R10 16-bit sweep", 8'h39, 3'd0, 1'b0, 32'hFFFF0000 | 32'(i * 1021),
          32'h12340000 | 32'(i * 977 + 32700), 32'h0, 1'b1, 1'b1,
          32'(i * 1021), 32'(i * 977 + 32700), 16);
    chk("R4 32-bit equal", 8'h39, 3'd0, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 32'h0,
        1'b1, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 32);
    // R5: 0x80 minus 1 at byte size, signed overflow
    chk("R5 byte 0x80-1 overflow", 8'h3C, 3'd0, 1'b0, 32'hFFFFFF80, 32'h0, 32'h01,
        1'b1, 1'b1, 32'h80, 32'h1, 8);
    // R3: 0 minus 1 at 32 bits, borrow
    chk("R3 32-bit 0-1 borrow", 8'h39, 3'd0, 1'b1, 32'h0, 32'h1, 32'h0,
        1'b1, 1'b1, 32'h0, 32'h1, 32);
    chk("R5 32-bit signed overflow", 8'h39, 3'd0, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0,
        1'b1, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32);
    // R8: reversed order forms
    chk("R8 0x3A reg first", 8'h3A, 3'd0, 1'b0, 32'h03, 32'h05, 32'h0,
        1'b1, 1'b1, 32'h05, 32'h03, 8);
    chk("R8 0x3B reg first 32", 8'h3B, 3'd0, 1'b1, 32'h00010000, 32'h0000FFFF, 32'h0,
        1'b1, 1'b1, 32'h0000FFFF, 32'h00010000, 32);
    chk("R8 0x38 rm first", 8'h38, 3'd0, 1'b0, 32'h03, 32'h05, 32'h0,
        1'b1, 1'b1, 32'h03, 32'h05, 8);
    // R9: short immediate extended to the operand width
    chk("R9 0x83 -1 vs 32-bit all ones", 8'h83, 3'd7, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h000000FF,
        1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32);
    chk("R9 0x83 -128 vs 16-bit", 8'h83, 3'd7, 1'b0, 32'h00000010, 32'h0, 32'h00000080,
        1'b1, 1'b1, 32'h0010, 32'hFF80, 16);
    chk("R9 0x80 byte immediate", 8'h80, 3'd7, 1'b0, 32'h00000042, 32'h0, 32'h000000C3,
        1'b1, 1'b1, 32'h42, 32'hC3, 8);
    chk("R9 0x81 full 32-bit immediate", 8'h81, 3'd7, 1'b1, 32'h80000000, 32'h0, 32'h00000001,
        1'b1, 1'b1, 32'h80000000, 32'h1, 32);
    chk("R9 0x81 16-bit immediate", 8'h81, 3'd7, 1'b0, 32'h00008000, 32'h0, 32'hFFFF0001,
        1'b1, 1'b1, 32'h8000, 32'h0001, 16);
    chk("R9 0x3D accumulator 16-bit", 8'h3D, 3'd0, 1'b0, 32'h0000000F, 32'h0, 32'h00000010,
        1'b1, 1'b1, 32'h000F, 32'h0010, 16);
    // R7: parity of low byte at 32 bits
    chk("R7 32-bit parity", 8'h39, 3'd0, 1'b1, 32'h12345603, 32'h00000000, 32'h0,
        1'b1, 1'b1, 32'h12345603, 32'h0, 32);
    // R1 R2: requests that must be ignored
    chk("R2 0x80 ext not 7 ignored", 8'h80, 3'd3, 1'b0, 32'h0, 32'h0, 32'h01,
        1'b1, 1'b0, 32'h0, 32'h0, 8);
    chk("R2 0x83 ext not 7 ignored", 8'h83, 3'd6, 1'b1, 32'h0, 32'h0, 32'hFF,
        1'b1, 1'b0, 32'h0, 32'h0, 32);
    chk("R2 unknown opcode ignored", 8'h00, 3'd7, 1'b1, 32'h5, 32'h9, 32'h0,
        1'b1, 1'b0, 32'h0, 32'h0, 32);
    chk("R1 in_valid low no strobe", 8'h39, 3'd0, 1'b1, 32'h0, 32'h1, 32'h0,
        1'b0, 1'b0, 32'h0, 32'h0, 32);
    chk("R1 strobe after idle", 8'h39, 3'd0, 1'b1, 32'h9, 32'h9, 32'h0,
        1'b1, 1'b1, 32'h9, 32'h9, 32);

    in_valid = 1'b0;
    // R11: reset clears strobe and flags after activity
    chk("R1 pre-reset", 8'h38, 3'd0, 1'b0, 32'h0, 32'h1, 32'h0,
        1'b1, 1'b1, 32'h0, 32'h1, 8);
    rst = 1'b1;
    @(negedge clk);
    total++;
    if ({flg_valid, cf, of, sf, zf, af, pf} !== 7'b0) begin
      bad++;
      $display("FAIL R11 reset after use got=%b exp=%b", {flg_valid, cf, of, sf, zf, af, pf}, 7'b0);
    end
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule